// File: doc/BRIEF.md
# Micro-op Align and Fuse Unit

This unit sits between the instruction fetch stage and the second-level decoders of a core that runs pre-translated micro-op code. Each cycle it can take one chunk of eight 16-bit parcels. Micro-ops in the chunk are either one or two parcels long. The unit finds where each micro-op starts and checks the pairing flag that software placed in its leading bit. When the flag is set, the micro-op and the one right after it become a single lane entry.

Parcels go into a small in-order queue. Every cycle up to three complete entries are read from the head of that queue and placed on the output lanes, oldest in lane 0. A micro-op, or a fused pair, that is cut by the end of the stored data stays in the queue until the next chunk completes it. A downstream stall holds the lanes steady. A full queue drops the input ready, which stalls fetch. A flush empties the queue.

Top module: `uop_align_fuse`

## Requirements
- R1: After reset no lane is valid and `in_ready` is high.
- R2: Parcel i of `in_chunk` is bits [16i+15:16i], and parcel 0 is the oldest. Entries leave in parcel order. The first parcel of a two-parcel micro-op becomes bits 31:16 of its field.
- R3: Parcel bit 14 of a micro-op's first parcel selects its length: 0 means one parcel, 1 means two parcels. A one-parcel micro-op is delivered in bits 31:16 of its field, with bits 15:0 zero. The `*_long` flag shows the length.
- R4: When bit 15 of a micro-op's first parcel is set, the next micro-op is its tail. Head and tail share one lane, and `lane_fused` is high for that lane. In an unfused lane the tail field and `lane_tail_long` are zero.
- R5: The pairing bit of a tail has no effect. The micro-op after a tail starts a new entry.
- R6: Up to three entries are offered per cycle, oldest first from lane 0. Lane k is valid only if lane k-1 is valid.
- R7: A micro-op or pair whose last parcel is not yet stored is not offered. It is offered whole once the next chunk supplies the missing parcels.
- R8: While `out_ready` is low, the offered lanes hold their contents. When `out_ready` is high, all valid lanes are consumed in that cycle, and entries beyond three wait for later cycles.
- R9: The queue holds 16 parcels. `in_ready` is high exactly when at least 8 parcels are free. A chunk offered while `in_ready` is low is not taken.
- R10: `flush` empties the queue. In the next cycle no lane is valid, and a chunk offered in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears all buffered parcels |
| in_valid | input | 1 | Fetch chunk present |
| in_ready | output | 1 | Room for one chunk |
| in_chunk | input | 128 | Eight parcels, parcel 0 in the low bits |
| out_ready | input | 1 | Downstream takes all valid lanes this cycle |
| lane_valid | output | 3 | Lane holds an entry |
| lane_fused | output | 3 | Lane holds a head and tail pair |
| lane_head_long | output | 3 | Head is two parcels |
| lane_tail_long | output | 3 | Tail is two parcels |
| lane_head | output | 96 | Head micro-op per lane, 32 bits each |
| lane_tail | output | 96 | Tail micro-op per lane, 32 bits each |

## Verification
The bench uses the default parameters: eight-parcel chunks, three lanes and a sixteen-parcel queue. With these values, a chunk of eight short micro-ops takes three drain cycles, so the last lane runs empty partway through a drain. The tests place a two-parcel micro-op and a fused head on the final parcel of a chunk so that each is split across chunks. The queue holds exactly two chunks, so two stalled pushes fill it and make the dropped-chunk case reachable.

// File: rtl/align_fuse_pkg.sv
package align_fuse_pkg;

    localparam int PARCEL_W = 16;
    localparam int UOP_W    = 32;
    localparam int FUSE_BIT = 15;
    localparam int LONG_BIT = 14;
    localparam int MAX_ENTRY_PARCELS = 4;

    typedef logic [PARCEL_W-1:0] parcel_t;

    typedef struct packed {
        logic             valid;
        logic             fused;
        logic             head_long;
        logic             tail_long;
        logic [UOP_W-1:0] head;
        logic [UOP_W-1:0] tail;
    } lane_entry_t;

    // Builds a left-justified micro-op field from its parcels.
    function automatic logic [UOP_W-1:0] join_uop(parcel_t first, parcel_t second, logic is_long);
        return is_long ? {first, second} : {first, {PARCEL_W{1'b0}}};
    endfunction

    function automatic int parcel_len(parcel_t first);
        return first[LONG_BIT] ? 2 : 1;
    endfunction

endpackage

// File: rtl/parcel_queue.sv
module parcel_queue
    import align_fuse_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IN_N  = 8,
    parameter int WIN   = 12,
    parameter int POP_W = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  push,
    input  parcel_t [IN_N-1:0]    in_parcels,
    input  logic [POP_W-1:0]      pop_n,
    output parcel_t [WIN-1:0]     win,
    output logic [CW-1:0]         count,
    output logic                  space_ok
);

    parcel_t          mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(IN_N);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            count  <= count + (push ? CW'(IN_N) : CW'(0)) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !rst && !flush) begin
            for (int i = 0; i < IN_N; i++) begin
                mem[wr_ptr + PTR_W'(i)] <= in_parcels[i];
            end
        end
    end

    generate
        for (genvar j = 0; j < WIN; j++) begin : g_win
            assign win[j] = mem[rd_ptr + PTR_W'(j)];
        end
    endgenerate

    assign space_ok = (int'(count) <= DEPTH - IN_N);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH) else $error("queue count above depth"); // R9

    AST_POP_WITHIN: assert property (@(posedge clk) disable iff (rst)
        int'(pop_n) <= int'(count)) else $error("pop beyond stored parcels"); // R7

endmodule

// File: rtl/lane_parser.sv
module lane_parser
    import align_fuse_pkg::*;
#(
    parameter int WIN = 12,
    parameter int OW  = 4,
    parameter int CW  = 5
) (
    input  parcel_t [WIN-1:0] win,
    input  logic [OW-1:0]     offset,
    input  logic [CW-1:0]     avail,
    input  logic              prev_ok,
    output lane_entry_t       entry,
    output logic [2:0]        used,
    output logic              ok
);

    always_comb begin
        int      o;
        int      n;
        int      len0;
        int      len1;
        parcel_t h0, h1, t0, t1;
        logic    fuse;
        logic    complete;

        o = int'(offset);
        n = int'(avail);
        h0 = '0;
        h1 = '0;
        for (int j = 0; j < WIN; j++) begin
            if (j == o)     h0 = win[j];
            if (j == o + 1) h1 = win[j];
        end
        len0 = parcel_len(h0);
        fuse = h0[FUSE_BIT];

        t0 = '0;
        t1 = '0;
        for (int j = 0; j < WIN; j++) begin
            if (j == o + len0)     t0 = win[j];
            if (j == o + len0 + 1) t1 = win[j];
        end
        len1 = fuse ? parcel_len(t0) : 0;

        complete = (o + len0 <= n) &&
                   (!fuse || ((o + len0 + 1 <= n) && (o + len0 + len1 <= n)));
        ok = prev_ok && complete;

        entry = '0;
        used  = '0;
        if (ok) begin
            entry.valid     = 1'b1;
            entry.fused     = fuse;
            entry.head_long = h0[LONG_BIT];
            entry.head      = join_uop(h0, h1, h0[LONG_BIT]);
            if (fuse) begin
                entry.tail_long = t0[LONG_BIT];
                entry.tail      = join_uop(t0, t1, t0[LONG_BIT]);
            end
            used = 3'(len0 + len1);
        end
    end

endmodule

// File: rtl/uop_align_fuse.sv
module uop_align_fuse
    import align_fuse_pkg::*;
#(
    parameter int CHUNK_PARCELS = 8,
    parameter int LANES         = 3,
    parameter int QDEPTH        = 16,
    localparam int CHUNK_W = CHUNK_PARCELS * PARCEL_W,
    localparam int WIN     = LANES * MAX_ENTRY_PARCELS,
    localparam int OW      = $clog2(WIN + 1),
    localparam int CW      = $clog2(QDEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [CHUNK_W-1:0]     in_chunk,
    input  logic                   out_ready,
    output logic [LANES-1:0]       lane_valid,
    output logic [LANES-1:0]       lane_fused,
    output logic [LANES-1:0]       lane_head_long,
    output logic [LANES-1:0]       lane_tail_long,
    output logic [LANES*UOP_W-1:0] lane_head,
    output logic [LANES*UOP_W-1:0] lane_tail
);

    parcel_t [CHUNK_PARCELS-1:0] chunk_parcels;
    parcel_t [WIN-1:0]           win;
    logic [CW-1:0]               count;
    logic                        space_ok;
    logic                        push;
    logic [OW-1:0]               pop_n;

    logic [OW-1:0]               offs    [LANES+1];
    logic                        ok_chain[LANES+1];
    lane_entry_t                 entries [LANES];

    assign chunk_parcels = in_chunk;
    assign push          = in_valid && space_ok && !flush;
    assign in_ready      = space_ok;

    parcel_queue #(
        .DEPTH (QDEPTH),
        .IN_N  (CHUNK_PARCELS),
        .WIN   (WIN),
        .POP_W (OW)
    ) u_queue (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .push       (push),
        .in_parcels (chunk_parcels),
        .pop_n      (pop_n),
        .win        (win),
        .count      (count),
        .space_ok   (space_ok)
    );

    assign offs[0]     = '0;
    assign ok_chain[0] = 1'b1;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [2:0] used_k;

            lane_parser #(
                .WIN (WIN),
                .OW  (OW),
                .CW  (CW)
            ) u_parse (
                .win     (win),
                .offset  (offs[k]),
                .avail   (count),
                .prev_ok (ok_chain[k]),
                .entry   (entries[k]),
                .used    (used_k),
                .ok      (ok_chain[k+1])
            );

            assign offs[k+1] = offs[k] + OW'(used_k);

            assign lane_valid[k]                = entries[k].valid;
            assign lane_fused[k]                = entries[k].fused;
            assign lane_head_long[k]            = entries[k].head_long;
            assign lane_tail_long[k]            = entries[k].tail_long;
            assign lane_head[k*UOP_W +: UOP_W]  = entries[k].head;
            assign lane_tail[k*UOP_W +: UOP_W]  = entries[k].tail;

            if (k > 0) begin : g_order
                AST_LANES_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
                    lane_valid[k] |-> lane_valid[k-1]) else $error("lane gap"); // R6
            end
        end
    endgenerate

    assign pop_n = out_ready ? offs[LANES] : '0;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lane_valid[0] && !out_ready && !flush) |=>
            (lane_valid[0] && $stable(lane_head[UOP_W-1:0]) && $stable(lane_fused[0])))
        else $error("lane changed under stall"); // R8

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (lane_valid == '0)) else $error("lanes survive flush"); // R10

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (lane_valid == '0 && in_ready)) else $error("reset state"); // R1

endmodule

// File: tb/sim_uop_align_fuse.sv
`timescale 1ns/1ps
module sim_uop_align_fuse;

    logic         clk = 1'b0;
    logic         rst;
    logic         flush;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_chunk;
    logic         out_ready;
    logic [2:0]   lane_valid, lane_fused, lane_head_long, lane_tail_long;
    logic [95:0]  lane_head, lane_tail;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uop_align_fuse u0 (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_chunk(in_chunk),
        .out_ready(out_ready),
        .lane_valid(lane_valid), .lane_fused(lane_fused),
        .lane_head_long(lane_head_long), .lane_tail_long(lane_tail_long),
        .lane_head(lane_head), .lane_tail(lane_tail)
    );

    function automatic logic [15:0] s16(logic f, int v);
        return {f, 1'b0, 14'(v)};
    endfunction

    function automatic logic [15:0] l16(logic f, int v);
        return {f, 1'b1, 14'(v)};
    endfunction

    task automatic check(logic cond, string req, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_lane(int k, logic v, logic f, logic hl, logic tl,
                              logic [31:0] h, logic [31:0] t, string req);
        logic [67:0] act, exp;
        act = {lane_valid[k], lane_fused[k], lane_head_long[k], lane_tail_long[k],
               lane_head[k*32 +: 32], lane_tail[k*32 +: 32]};
        exp = {v, f, hl, tl, h, t};
        check(act == exp, req, 96'(act), 96'(exp));
    endtask

    task automatic tick(logic ordy, logic ivld, logic fl, logic [127:0] ch);
        out_ready = ordy;
        in_valid  = ivld;
        flush     = fl;
        in_chunk  = ch;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b0;
        flush     = 1'b0;
    endtask

    task automatic test_reset();
        check(lane_valid == 3'b000, "R1 lanes after reset", 96'(lane_valid), 96'(0));
        check(in_ready == 1'b1, "R1 in_ready after reset", 96'(in_ready), 96'(1));
    endtask

    task automatic test_plain();
        logic [7:0][15:0] c;
        tick(0, 0, 1, '0);
        for (int i = 0; i < 8; i++) c[i] = s16(0, i + 1);
        tick(0, 1, 0, c);
        for (int k = 0; k < 3; k++)
            check_lane(k, 1, 0, 0, 0, {s16(0, k + 1), 16'h0}, 32'h0, "R2 R3 R6 first lanes");
        tick(0, 0, 0, '0);
        for (int k = 0; k < 3; k++)
            check_lane(k, 1, 0, 0, 0, {s16(0, k + 1), 16'h0}, 32'h0, "R8 held under stall");
        tick(1, 0, 0, '0);
        for (int k = 0; k < 3; k++)
            check_lane(k, 1, 0, 0, 0, {s16(0, k + 4), 16'h0}, 32'h0, "R8 next three");
        tick(1, 0, 0, '0);
        check_lane(0, 1, 0, 0, 0, {s16(0, 7), 16'h0}, 32'h0, "R6 partial lane0");
        check_lane(1, 1, 0, 0, 0, {s16(0, 8), 16'h0}, 32'h0, "R6 partial lane1");
        check_lane(2, 0, 0, 0, 0, 32'h0, 32'h0, "R6 lane2 empty");
        tick(1, 0, 0, '0);
        check(lane_valid == 3'b000, "R8 drained", 96'(lane_valid), 96'(0));
    endtask

    task automatic test_pairs();
        logic [7:0][15:0] c;
        tick(0, 0, 1, '0);
        c[0] = s16(1, 'h11);
        c[1] = l16(0, 'h22);
        c[2] = 16'hBEEF;
        c[3] = l16(1, 'h33);
        c[4] = 16'h1234;
        c[5] = s16(0, 'h44);
        c[6] = s16(0, 'h55);
        c[7] = s16(0, 'h66);
        tick(0, 1, 0, c);
        check_lane(0, 1, 1, 0, 1, {c[0], 16'h0}, {c[1], c[2]}, "R4 short head long tail");
        check_lane(1, 1, 1, 1, 0, {c[3], c[4]}, {c[5], 16'h0}, "R4 R3 long head short tail");
        check_lane(2, 1, 0, 0, 0, {c[6], 16'h0}, 32'h0, "R4 unfused tail zero");
    endtask

    task automatic test_tail_flag();
        logic [7:0][15:0] c;
        tick(0, 0, 1, '0);
        c[0] = s16(1, 'h01);
        c[1] = s16(1, 'h02);
        for (int i = 2; i < 8; i++) c[i] = s16(0, 'h10 + i);
        tick(0, 1, 0, c);
        check_lane(0, 1, 1, 0, 0, {c[0], 16'h0}, {c[1], 16'h0}, "R5 pair formed");
        check_lane(1, 1, 0, 0, 0, {c[2], 16'h0}, 32'h0, "R5 tail flag ignored");
        check_lane(2, 1, 0, 0, 0, {c[3], 16'h0}, 32'h0, "R5 following entry");
    endtask

    task automatic test_split(logic pair_case);
        logic [7:0][15:0] a, b;
        tick(0, 0, 1, '0);
        for (int i = 0; i < 7; i++) a[i] = s16(0, 'h200 + i);
        a[7] = pair_case ? s16(1, 'h2AA) : l16(0, 'h2BB);
        for (int i = 0; i < 8; i++) b[i] = s16(0, 'h300 + i);
        if (!pair_case) b[0] = 16'hCAFE;
        tick(0, 1, 0, a);
        tick(1, 0, 0, '0);
        tick(1, 0, 0, '0);
        check_lane(0, 1, 0, 0, 0, {a[6], 16'h0}, 32'h0, "R7 last whole entry");
        check_lane(1, 0, 0, 0, 0, 32'h0, 32'h0, "R7 incomplete not offered");
        tick(1, 1, 0, b);
        if (pair_case)
            check_lane(0, 1, 1, 0, 0, {a[7], 16'h0}, {b[0], 16'h0}, "R7 pair completed");
        else
            check_lane(0, 1, 0, 1, 0, {a[7], b[0]}, 32'h0, "R7 long uop completed");
        check_lane(1, 1, 0, 0, 0, {b[1], 16'h0}, 32'h0, "R7 following entry");
    endtask

    task automatic test_full();
        logic [7:0][15:0] c;
        int exp_i;
        tick(0, 0, 1, '0);
        for (int i = 0; i < 8; i++) c[i] = s16(0, 'h100 + i);
        tick(0, 1, 0, c);
        check(in_ready == 1'b1, "R9 ready at half", 96'(in_ready), 96'(1));
        for (int i = 0; i < 8; i++) c[i] = s16(0, 'h108 + i);
        tick(0, 1, 0, c);
        check(in_ready == 1'b0, "R9 not ready when full", 96'(in_ready), 96'(0));
        for (int i = 0; i < 8; i++) c[i] = s16(0, 'h3FFF);
        tick(0, 1, 0, c);
        check(in_ready == 1'b0, "R9 still full", 96'(in_ready), 96'(0));
        exp_i = 0;
        while (exp_i < 16) begin
            for (int k = 0; k < 3; k++) begin
                if (exp_i + k < 16)
                    check_lane(k, 1, 0, 0, 0, {s16(0, 'h100 + exp_i + k), 16'h0}, 32'h0, "R9 R8 drain order");
                else
                    check_lane(k, 0, 0, 0, 0, 32'h0, 32'h0, "R9 drain tail");
            end
            tick(1, 0, 0, '0);
            exp_i += (16 - exp_i < 3) ? 16 - exp_i : 3;
        end
        check(lane_valid == 3'b000, "R9 refused chunk absent", 96'(lane_valid), 96'(0));
    endtask

    task automatic test_flush();
        logic [7:0][15:0] c;
        for (int i = 0; i < 8; i++) c[i] = s16(0, 'h400 + i);
        tick(0, 1, 0, c);
        check(lane_valid[0] == 1'b1, "R10 data before flush", 96'(lane_valid), 96'(1));
        tick(0, 1, 1, c);
        check(lane_valid == 3'b000, "R10 empty after flush", 96'(lane_valid), 96'(0));
        check(in_ready == 1'b1, "R10 ready after flush", 96'(in_ready), 96'(1));
        tick(0, 0, 0, '0);
        check(lane_valid == 3'b000, "R10 flush-cycle chunk dropped", 96'(lane_valid), 96'(0));
    endtask

    initial begin
        rst = 1'b1; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_chunk = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_plain();
        test_pairs();
        test_tail_flag();
        test_split(1'b0);
        test_split(1'b1);
        test_full();
        test_flush();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule